// File: doc/BRIEF.md
# Banked RAM expansion controller

This block maps CPU and video accesses onto a single 512K RAM array divided into thirty-two 16K pages. The array has no separate 64K base memory. Pages 0..3 take the place of the base memory. Pages 4..31 form seven 64K expansion groups of four pages each. The CPU sets up the mapping with an I/O write. The block decodes that write and keeps six bits of it as the banking configuration. From the configuration and the top two CPU address bits it produces the physical page for each CPU access, with no clock delay.

The display fetch path has its own 18-bit address, of which the block sees bits 17..14 as a video page index. Video fetches therefore reach the lower half of the array, 256K. Inside each 64K video slice, the second 16K window follows the page that the CPU has mapped at 4000h..7FFFh, in its low two bits. The display can thus show any of pages 0..3 there, not only a fixed page. No input exists for external hardware to disable the RAM.

Top module: `ram_bank_ctrl`

## Requirements
- R1: After reset the configuration is layout 0 with group 0, so `cpu_page_o` equals `cpu_addr_i[15:14]`.
- R2: A configuration write is a cycle with `iorq_ni`=0, `wr_ni`=0, `cpu_addr_i[15]`=0 and `cpu_data_i[7:6]`=2'b11. Bits 2..0 of the data select the layout and bits 5..3 select the group. The new configuration takes effect on the first clock edge at which the write is no longer active, and not earlier.
- R3: A write with `cpu_addr_i[15]`=1, or with `cpu_data_i[7:6]` other than 2'b11, leaves the mapping unchanged.
- R4: The page indices for CPU windows 0000h/4000h/8000h/C000h are as follows. Layout 0 gives 0,1,2,3. Layout 1 gives 0,1,2,X3. Layout 2 gives X0,X1,X2,X3. Layout 3 gives 0,3,2,X3. Layouts 4..7 give 0,Xk,2,3 with k = layout-4.
- R5: The expansion page Xk of group g is physical page (4 + 4g + k) mod 32. Group 7 therefore aliases pages 0..3.
- R6: Data bytes FCh..FFh (group 7 with layout 4..7) are ignored, and the previous mapping stays in force.
- R7: `vid_page_o[4]` is always 0 and `vid_page_o[3:2]` equals `vid_idx_i[3:2]`. `vid_page_o[1:0]` equals `vid_idx_i[1:0]`, except when `vid_idx_i[1:0]`=1. In that case it equals the low two bits of the page mapped at CPU window 4000h.
- R8: `cpu_page_o` follows `cpu_addr_i[15:14]` with no clock delay, using the current configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| iorq_ni | input | 1 | I/O request, active low |
| wr_ni | input | 1 | Write strobe, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| vid_idx_i | input | 4 | Video address bits 17..14 |
| cpu_page_o | output | 5 | Physical page for the CPU access |
| vid_page_o | output | 5 | Physical page for the video fetch |

## Verification
The assertions check the following on every cycle:
- the video page stays in the lower half of the array and passes through the video index outside window 1;
- in window 1 the video page follows the CPU's 4000h page whenever both paths address that window;
- the configuration changes only two cycles after an active port write;
- a configuration from the unused range is never stored;
- window 0000h stays on page 0 outside layout 2.

Only the bench scenarios can show the complete page table for every layout and group, including the wrap of group 7. They also show the exact cycle at which a write takes effect, and that writes with the wrong address or data prefix leave the mapping untouched.

// File: rtl/ram_bank_pkg.sv
package ram_bank_pkg;
  localparam int PAGE_W    = 5;
  localparam int VID_IDX_W = 4;
  localparam int N_WIN     = 4;
  localparam int BASE_PGS  = 4;

  typedef struct packed {
    logic [2:0] grp;
    logic [2:0] layout;
  } bank_cfg_t;
endpackage

// File: rtl/bank_port_decode.sv
module bank_port_decode
  import ram_bank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       iorq_ni,
  input  logic       wr_ni,
  input  logic       a15_i,
  input  logic [7:0] data_i,
  output bank_cfg_t  cfg_o
);
  logic      strobe, strobe_q, unused;
  bank_cfg_t data_q, cfg_q;

  assign strobe = !iorq_ni && !wr_ni && !a15_i && (data_i[7:6] == 2'b11);
  // group 7 with layout 4..7 is the reserved range
  assign unused = (data_q.grp == 3'd7) && data_q.layout[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      data_q   <= '0;
      cfg_q    <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe) data_q <= bank_cfg_t'(data_i[5:0]);
      if (strobe_q && !strobe && !unused) cfg_q <= data_q;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/bank_page_map.sv
module bank_page_map
  import ram_bank_pkg::*;
(
  input  bank_cfg_t                     cfg_i,
  output logic [N_WIN-1:0][PAGE_W-1:0]  win_page_o
);
  logic [N_WIN-1:0][PAGE_W-1:0] exp_page;

  for (genvar k = 0; k < N_WIN; k++) begin : g_exp
    localparam logic [PAGE_W-1:0] OFS = PAGE_W'(BASE_PGS + k);
    assign exp_page[k] = OFS + {cfg_i.grp, 2'b00};
  end

  always_comb begin
    for (int w = 0; w < N_WIN; w++) win_page_o[w] = PAGE_W'(w);
    unique case (cfg_i.layout)
      3'd0: ;
      3'd1: win_page_o[3] = exp_page[3];
      3'd2: win_page_o = exp_page;
      3'd3: begin
        win_page_o[1] = PAGE_W'(3);
        win_page_o[3] = exp_page[3];
      end
      default: win_page_o[1] = exp_page[cfg_i.layout[1:0]];
    endcase
  end
endmodule

// File: rtl/bank_video_map.sv
module bank_video_map
  import ram_bank_pkg::*;
(
  input  logic [VID_IDX_W-1:0] vid_idx_i,
  input  logic [PAGE_W-1:0]    win1_page_i,
  output logic [PAGE_W-1:0]    vid_page_o
);
  logic [1:0] low_bits;

  assign low_bits   = (vid_idx_i[1:0] == 2'd1) ? win1_page_i[1:0] : vid_idx_i[1:0];
  assign vid_page_o = {{(PAGE_W-VID_IDX_W){1'b0}}, vid_idx_i[VID_IDX_W-1:2], low_bits};
endmodule

// File: rtl/ram_bank_ctrl.sv
module ram_bank_ctrl
  import ram_bank_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 iorq_ni,
  input  logic                 wr_ni,
  input  logic [15:0]          cpu_addr_i,
  input  logic [7:0]           cpu_data_i,
  input  logic [VID_IDX_W-1:0] vid_idx_i,
  output logic [PAGE_W-1:0]    cpu_page_o,
  output logic [PAGE_W-1:0]    vid_page_o
);
  bank_cfg_t                    cfg_q;
  logic [N_WIN-1:0][PAGE_W-1:0] win_page;

  bank_port_decode u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .iorq_ni(iorq_ni),
    .wr_ni  (wr_ni),
    .a15_i  (cpu_addr_i[15]),
    .data_i (cpu_data_i),
    .cfg_o  (cfg_q)
  );

  bank_page_map u_map (
    .cfg_i     (cfg_q),
    .win_page_o(win_page)
  );

  assign cpu_page_o = win_page[cpu_addr_i[15:14]];

  bank_video_map u_vid (
    .vid_idx_i  (vid_idx_i),
    .win1_page_i(win_page[1]),
    .vid_page_o (vid_page_o)
  );
endmodule

// File: rtl/ram_bank_ctrl_chk.sv
module ram_bank_ctrl_chk
  import ram_bank_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 iorq_ni,
  input logic                 wr_ni,
  input logic [15:0]          cpu_addr_i,
  input logic [VID_IDX_W-1:0] vid_idx_i,
  input logic [PAGE_W-1:0]    cpu_page_o,
  input logic [PAGE_W-1:0]    vid_page_o,
  input bank_cfg_t            cfg_q
);
  assert_vid_half_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_page_o[PAGE_W-1:2] == {1'b0, vid_idx_i[3:2]});

  assert_vid_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_idx_i[1:0] != 2'd1) |-> (vid_page_o[1:0] == vid_idx_i[1:0]));

  assert_vid_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_idx_i[1:0] == 2'd1 && cpu_addr_i[15:14] == 2'd1)
      |-> (vid_page_o[1:0] == cpu_page_o[1:0]));

  assert_cfg_after_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> $past(!iorq_ni && !wr_ni && !cpu_addr_i[15], 2));

  assert_no_reserved_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_q.grp == 3'd7 && cfg_q.layout[2]));

  assert_win0_base_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15:14] == 2'd0 && cfg_q.layout != 3'd2) |-> (cpu_page_o == '0));
endmodule

bind ram_bank_ctrl ram_bank_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .iorq_ni   (iorq_ni),
  .wr_ni     (wr_ni),
  .cpu_addr_i(cpu_addr_i),
  .vid_idx_i (vid_idx_i),
  .cpu_page_o(cpu_page_o),
  .vid_page_o(vid_page_o),
  .cfg_q     (cfg_q)
);

// File: tb/ram_bank_ctrl_tb_top.sv
module ram_bank_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iorq_n = 1'b1, wr_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [3:0]  vid_idx = '0;
  logic [4:0]  cpu_page, vid_page;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // reference state
  int m_layout = 0, m_grp = 0, m_data = 0;
  bit m_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ram_bank_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .iorq_ni(iorq_n), .wr_ni(wr_n),
    .cpu_addr_i(addr), .cpu_data_i(data), .vid_idx_i(vid_idx),
    .cpu_page_o(cpu_page), .vid_page_o(vid_page)
  );

  function automatic int xpage(int g, int k);
    return (4 + 4*g + k) % 32;
  endfunction

  function automatic int ref_cpu(int lay, int g, int win);
    int p;
    p = win;
    case (lay)
      0: ;
      1: if (win == 3) p = xpage(g, 3);
      2: p = xpage(g, win);
      3: begin if (win == 1) p = 3; if (win == 3) p = xpage(g, 3); end
      default: if (win == 1) p = xpage(g, lay - 4);
    endcase
    return p;
  endfunction

  function automatic int ref_vid(int lay, int g, int idx);
    int lo;
    lo = idx % 4;
    if (lo == 1) lo = ref_cpu(lay, g, 1) % 4;
    return (idx / 4) * 4 + lo;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit act;
    if (!rst_n) begin
      m_layout <= 0; m_grp <= 0; m_prev <= 1'b0; m_data <= 0;
    end else begin
      act = !iorq_n && !wr_n && !addr[15] && data[7:6] == 2'b11;
      m_prev <= act;
      if (act) m_data <= int'(data[5:0]);
      if (m_prev && !act && !(m_data >= 'h3C)) begin
        m_layout <= m_data % 8;
        m_grp    <= m_data / 8;
      end
    end
  end

  always @(negedge clk) begin
    int ec, ev;
    if (rst_n && !done) begin
      ec = ref_cpu(m_layout, m_grp, int'(addr[15:14]));
      ev = ref_vid(m_layout, m_grp, int'(vid_idx));
      n_cmp += 2;
      if (int'(cpu_page) != ec) begin
        n_bad++;
        $display("FAIL %s cpu_page actual=%0d expected=%0d", cur_req, cpu_page, ec);
      end
      if (int'(vid_page) != ev) begin
        n_bad++;
        $display("FAIL %s vid_page actual=%0d expected=%0d", cur_req, vid_page, ev);
      end
    end
  end

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; data = d; iorq_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic sweep();
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      addr = 16'(k % 4) << 14;
      vid_idx = 4'(k);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    cur_req = "R1"; sweep();
    cur_req = "R2_R4_R5_R8";
    for (int g = 0; g < 8; g++) begin
      for (int l = 0; l < 8; l++) begin
        if (g == 7 && l >= 4) continue;
        io_write(16'h7F00, 8'(8'hC0 + g*8 + l));
        sweep();
      end
    end
    cur_req = "R6";
    io_write(16'h7F00, 8'hD6);
    for (int v = 'hFC; v <= 'hFF; v++) begin
      io_write(16'h7F00, 8'(v));
      sweep();
    end
    cur_req = "R3";
    io_write(16'hFF00, 8'hC2);
    sweep();
    io_write(16'h7F00, 8'h82);
    sweep();
    cur_req = "R7";
    io_write(16'h7F00, 8'hF2);
    sweep();
    io_write(16'h7F00, 8'hC7);
    sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule